// File: doc/BRIEF.md
# Calendar Time and Date Counter

This block keeps wall-clock time and calendar date in one packed 32-bit word. An external prescaler supplies a one-cycle pulse once per second. While the calendar enable is high, each such pulse advances the value by one second. The carry then ripples through minutes, hours, day of month, month and a 6-bit year offset. The year offset counts from a leap year that software picks, and every offset divisible by four is treated as a leap year.

Software loads the value through a write strobe with a full data word. It reads the value back on a plain output bus. A second register in the same packed format holds an alarm time, and a match output follows the comparison between the two registers. When the year offset steps past its largest value, it returns to zero and the block pulses an overflow output.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the value reads 0 s, 0 min, 0 h, day 1, month 1, year offset 0, the alarm register reads all zeros, and both `alarmHit` and `yearWrap` are low.
- R2: The packed value places, from bit 0 upward: seconds [5:0], minutes [11:6], hours [16:12], day of month [21:17], month [25:22], year offset [31:26].
- R3: A tick advances the value only while `calEn` is high. With `calEn` low, ticks leave the value unchanged.
- R4: Seconds count 0 to 59. A tick at 59 gives 0 and adds one minute. Minutes behave the same way into hours. Hours count 0 to 23 in 24-hour form, and a tick at 23:59:59 adds one day.
- R5: The day of month starts at 1. After the last day it returns to 1 and the month advances. Months 4, 6, 9 and 11 have 30 days, and months 1, 3, 5, 7, 8, 10 and 12 have 31 days.
- R6: February has 29 days when the year offset is divisible by 4 (its two low bits are zero) and 28 days otherwise.
- R7: Months run from 1 (January) to 12 (December). Advancing past month 12 gives month 1 and increments the year offset.
- R8: Advancing past year offset 63 gives offset 0. `yearWrap` is high for exactly the one cycle after that tick and low at all other times.
- R9: When `wrEn` is high, `wrData` appears on `calValue` in the next cycle. This happens whatever `calEn` is, and it wins over a tick in the same cycle.
- R10: When `almWrEn` is high, `almWrData` appears on `almValue` in the next cycle. `alarmHit` is high exactly while `calValue` equals `almValue`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| calEn | input | 1 | Calendar counting enable |
| secTick | input | 1 | One-second pulse from the prescaler |
| wrEn | input | 1 | Load strobe for the calendar value |
| wrData | input | 32 | Packed value to load |
| almWrEn | input | 1 | Load strobe for the alarm register |
| almWrData | input | 32 | Packed alarm value to load |
| calValue | output | 32 | Current packed time and date |
| almValue | output | 32 | Current packed alarm value |
| alarmHit | output | 1 | High while value equals alarm |
| yearWrap | output | 1 | One-cycle pulse when year offset wraps to 0 |

## Verification
The hardest situation to reach is the year-offset wrap. From reset it would take 64 years of one-second ticks. The stimulus therefore loads 23:59:59 on the last day of December at offset 63 and applies a single tick.

Each February case is reached the same way, by loading the last second of the 28th or 29th in a leap and a non-leap offset. A load coinciding with a tick, and ticks with the enable low, are applied on purpose so that the priority rules show at the output.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int SEC_W = 6;
  localparam int MIN_W = 6;
  localparam int HR_W  = 5;
  localparam int DAY_W = 5;
  localparam int MON_W = 4;
  localparam int YR_W  = 6;
  localparam int CAL_W = SEC_W + MIN_W + HR_W + DAY_W + MON_W + YR_W;

  localparam int SEC_LO = 0;
  localparam int MIN_LO = SEC_LO + SEC_W;
  localparam int HR_LO  = MIN_LO + MIN_W;
  localparam int DAY_LO = HR_LO + HR_W;
  localparam int MON_LO = DAY_LO + DAY_W;
  localparam int YR_LO  = MON_LO + MON_W;

  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(59);
  localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(59);
  localparam logic [HR_W-1:0]  HR_LAST  = HR_W'(23);
  localparam logic [MON_W-1:0] MON_LAST = MON_W'(12);
  localparam logic [YR_W-1:0]  YR_LAST  = {YR_W{1'b1}};

  typedef struct packed {
    logic load;
    logic adv;
    logic secCy;
    logic minCy;
    logic hrCy;
    logic dayCy;
    logic monCy;
    logic yrCy;
  } calStrobe_t;
endpackage

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
(
  input  logic             calEn,
  input  logic             secTick,
  input  logic             wrEn,
  input  logic [CAL_W-1:0] curVal,
  output calStrobe_t       stb
);
  logic [SEC_W-1:0] secF;
  logic [MIN_W-1:0] minF;
  logic [HR_W-1:0]  hrF;
  logic [DAY_W-1:0] dayF;
  logic [MON_W-1:0] monF;
  logic [YR_W-1:0]  yrF;
  logic [DAY_W-1:0] lastDay;
  logic             leapYr;

  assign secF = curVal[SEC_LO +: SEC_W];
  assign minF = curVal[MIN_LO +: MIN_W];
  assign hrF  = curVal[HR_LO  +: HR_W];
  assign dayF = curVal[DAY_LO +: DAY_W];
  assign monF = curVal[MON_LO +: MON_W];
  assign yrF  = curVal[YR_LO  +: YR_W];

  assign leapYr = (yrF[1:0] == 2'b00);

  always_comb begin
    unique case (monF)
      MON_W'(2):                          lastDay = leapYr ? DAY_W'(29) : DAY_W'(28);
      MON_W'(4), MON_W'(6), MON_W'(9),
      MON_W'(11):                         lastDay = DAY_W'(30);
      default:                            lastDay = DAY_W'(31);
    endcase
  end

  always_comb begin
    stb.load  = wrEn;
    stb.adv   = secTick & calEn & ~wrEn;
    stb.secCy = stb.adv   & (secF == SEC_LAST);
    stb.minCy = stb.secCy & (minF == MIN_LAST);
    stb.hrCy  = stb.minCy & (hrF  == HR_LAST);
    stb.dayCy = stb.hrCy  & (dayF >= lastDay);
    stb.monCy = stb.dayCy & (monF >= MON_LAST);
    stb.yrCy  = stb.monCy & (yrF  == YR_LAST);
  end
endmodule

// File: rtl/rtc_cal_dp.sv
module rtc_cal_dp
  import rtc_cal_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  calStrobe_t       stb,
  input  logic [CAL_W-1:0] wrData,
  input  logic             almWrEn,
  input  logic [CAL_W-1:0] almWrData,
  output logic [CAL_W-1:0] curVal,
  output logic [CAL_W-1:0] almVal,
  output logic             wrapPulse
);
  logic [SEC_W-1:0] secR;
  logic [MIN_W-1:0] minR;
  logic [HR_W-1:0]  hrR;
  logic [DAY_W-1:0] dayR;
  logic [MON_W-1:0] monR;
  logic [YR_W-1:0]  yrR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secR <= '0;
      minR <= '0;
      hrR  <= '0;
      dayR <= DAY_W'(1);
      monR <= MON_W'(1);
      yrR  <= '0;
    end else if (stb.load) begin
      {yrR, monR, dayR, hrR, minR, secR} <= wrData;
    end else if (stb.adv) begin
      secR <= stb.secCy ? '0 : secR + SEC_W'(1);
      if (stb.secCy) minR <= stb.minCy ? '0 : minR + MIN_W'(1);
      if (stb.minCy) hrR  <= stb.hrCy  ? '0 : hrR + HR_W'(1);
      if (stb.hrCy)  dayR <= stb.dayCy ? DAY_W'(1) : dayR + DAY_W'(1);
      if (stb.dayCy) monR <= stb.monCy ? MON_W'(1) : monR + MON_W'(1);
      if (stb.monCy) yrR  <= yrR + YR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      almVal    <= '0;
      wrapPulse <= 1'b0;
    end else begin
      if (almWrEn) almVal <= almWrData;
      wrapPulse <= stb.yrCy;
    end
  end

  assign curVal = {yrR, monR, dayR, hrR, minR, secR};
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             calEn,
  input  logic             secTick,
  input  logic             wrEn,
  input  logic [CAL_W-1:0] wrData,
  input  logic             almWrEn,
  input  logic [CAL_W-1:0] almWrData,
  output logic [CAL_W-1:0] calValue,
  output logic [CAL_W-1:0] almValue,
  output logic             alarmHit,
  output logic             yearWrap
);
  calStrobe_t stb;

  rtc_cal_ctrl u_ctrl (
    .calEn   (calEn),
    .secTick (secTick),
    .wrEn    (wrEn),
    .curVal  (calValue),
    .stb     (stb)
  );

  rtc_cal_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (wrData),
    .almWrEn   (almWrEn),
    .almWrData (almWrData),
    .curVal    (calValue),
    .almVal    (almValue),
    .wrapPulse (yearWrap)
  );

  assign alarmHit = (calValue == almValue);
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import rtc_cal_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             calEn,
  input logic             secTick,
  input logic             wrEn,
  input logic [CAL_W-1:0] wrData,
  input logic             almWrEn,
  input logic [CAL_W-1:0] almWrData,
  input logic [CAL_W-1:0] calValue,
  input logic [CAL_W-1:0] almValue,
  input logic             alarmHit,
  input logic             yearWrap
);
  // R3: no tick or enable low and no load keeps the value
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && (!calEn || !secTick)) |=> $stable(calValue));

  // R9: a load lands on the next cycle
  a_r9_load: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (calValue == $past(wrData)));

  // R10: alarm register load
  a_r10_alm_load: assert property (@(posedge clk) disable iff (!rstN)
    almWrEn |=> (almValue == $past(almWrData)));

  // R4: a tick below 59 seconds steps only the seconds field
  a_r4_sec_step: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && calEn && !wrEn && calValue[SEC_LO +: SEC_W] < SEC_LAST) |=>
      (calValue[SEC_LO +: SEC_W] == $past(calValue[SEC_LO +: SEC_W]) + SEC_W'(1)) &&
      (calValue[CAL_W-1:MIN_LO] == $past(calValue[CAL_W-1:MIN_LO])));

  // R8: a wrap pulse follows a year offset of 63 and leaves offset 0
  a_r8_wrap_src: assert property (@(posedge clk) disable iff (!rstN)
    $rose(yearWrap) |-> ($past(calValue[YR_LO +: YR_W]) == YR_LAST) &&
                        (calValue[YR_LO +: YR_W] == '0));

  // R8: the pulse lasts one cycle unless a second wrap is impossible
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    yearWrap |=> !yearWrap);

  // R10: hit output agrees with the register comparison
  a_r10_hit: assert property (@(posedge clk) disable iff (!rstN)
    alarmHit |-> (calValue == almValue));
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .calEn     (calEn),
  .secTick   (secTick),
  .wrEn      (wrEn),
  .wrData    (wrData),
  .almWrEn   (almWrEn),
  .almWrData (almWrData),
  .calValue  (calValue),
  .almValue  (almValue),
  .alarmHit  (alarmHit),
  .yearWrap  (yearWrap)
);

// File: tb/sim_rtc_calendar.sv
module sim_rtc_calendar;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        calEn = 1'b0;
  logic        secTick = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        almWrEn = 1'b0;
  logic [31:0] almWrData = '0;
  logic [31:0] calValue;
  logic [31:0] almValue;
  logic        alarmHit;
  logic        yearWrap;

  int vecCnt = 0;
  int badCnt = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] val;
    logic [31:0] alm;
    logic        wrap;
    logic        hit;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  logic [31:0] mVal;
  logic [31:0] mAlm;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_calendar u0 (
    .clk(clk), .rstN(rstN), .calEn(calEn), .secTick(secTick),
    .wrEn(wrEn), .wrData(wrData), .almWrEn(almWrEn), .almWrData(almWrData),
    .calValue(calValue), .almValue(almValue), .alarmHit(alarmHit), .yearWrap(yearWrap)
  );

  // R2 layout: year[31:26] month[25:22] day[21:17] hour[16:12] min[11:6] sec[5:0]
  function automatic logic [31:0] pk(int yr, int mo, int dy, int hr, int mi, int sc);
    return {yr[5:0], mo[3:0], dy[4:0], hr[4:0], mi[5:0], sc[5:0]};
  endfunction

  function automatic int monthLen(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [32:0] nextSec(logic [31:0] v);
    int sc = v[5:0], mi = v[11:6], hr = v[16:12];
    int dy = v[21:17], mo = v[25:22], yr = v[31:26];
    logic w = 1'b0;
    sc++;
    if (sc == 60) begin sc = 0; mi++; end
    if (mi == 60) begin mi = 0; hr++; end
    if (hr == 24) begin hr = 0; dy++; end
    if (dy > monthLen(mo, yr)) begin dy = 1; mo++; end
    if (mo > 12) begin mo = 1; yr++; end
    if (yr == 64) begin yr = 0; w = 1'b1; end
    return {w, pk(yr, mo, dy, hr, mi, sc)};
  endfunction

  task automatic report(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vecCnt++;
    if (act !== exp) begin
      badCnt++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the expected result
  task automatic drive(bit tick, bit en, bit wr, logic [31:0] d,
                       bit aw, logic [31:0] ad, string tag);
    expItem_t it;
    logic [32:0] nx;
    logic w = 1'b0;
    @(negedge clk);
    secTick = tick; calEn = en; wrEn = wr; wrData = d;
    almWrEn = aw; almWrData = ad;
    if (wr) mVal = d;
    else if (tick && en) begin
      nx = nextSec(mVal);
      mVal = nx[31:0];
      w = nx[32];
    end
    if (aw) mAlm = ad;
    it.val = mVal; it.alm = mAlm; it.wrap = w; it.hit = (mVal == mAlm); it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic load(logic [31:0] d, string tag);
    drive(1'b0, 1'b1, 1'b1, d, 1'b0, '0, tag);
  endtask

  task automatic tick(string tag);
    drive(1'b1, 1'b1, 1'b0, '0, 1'b0, '0, tag);
  endtask

  // monitor: compare outputs just after each active edge
  initial begin
    expItem_t it;
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        report(it.tag, "value", calValue, it.val);
        report(it.tag, "alarm", almValue, it.alm);
        report(it.tag, "wrap", {31'b0, yearWrap}, {31'b0, it.wrap});
        report(it.tag, "hit", {31'b0, alarmHit}, {31'b0, it.hit});
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, badCnt);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    badCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    mVal = pk(0, 1, 1, 0, 0, 0);
    mAlm = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    report("R1", "value", calValue, pk(0, 1, 1, 0, 0, 0));
    report("R1", "alarm", almValue, 32'h0);
    report("R1", "flags", {30'b0, alarmHit, yearWrap}, 32'h0);

    // R4: run from reset across minute and hour carries
    for (int i = 0; i < 3700; i++) tick("R4");
    // R3: ticks with enable low are ignored
    for (int i = 0; i < 5; i++) drive(1'b1, 1'b0, 1'b0, '0, 1'b0, '0, "R3");
    for (int i = 0; i < 40; i++) drive(1'b1, (i % 3) != 0, 1'b0, '0, 1'b0, '0, "R3");
    // R2 / R9: loaded fields sit at their stated positions, loaded with enable low
    drive(1'b0, 1'b0, 1'b1, pk(37, 9, 17, 13, 45, 21), 1'b0, '0, "R9");
    tick("R2");
    // R4: end-of-day carry
    load(pk(3, 5, 10, 23, 59, 59), "R9"); tick("R4");
    // R5: 30 and 31 day months
    load(pk(3, 4, 30, 23, 59, 59), "R9"); tick("R5");
    load(pk(3, 1, 31, 23, 59, 59), "R5"); tick("R5");
    load(pk(3, 11, 30, 23, 59, 59), "R5"); tick("R5");
    load(pk(3, 8, 30, 23, 59, 59), "R5"); tick("R5");
    // R6: February in leap and common years
    load(pk(4, 2, 28, 23, 59, 59), "R6"); tick("R6"); tick("R6");
    load(pk(4, 2, 29, 23, 59, 59), "R6"); tick("R6");
    load(pk(5, 2, 28, 23, 59, 59), "R6"); tick("R6");
    // R7: year end
    load(pk(5, 12, 31, 23, 59, 58), "R7"); tick("R7"); tick("R7"); tick("R7");
    // R8: offset wrap and its one-cycle pulse
    load(pk(63, 12, 31, 23, 59, 59), "R8"); tick("R8");
    drive(1'b0, 1'b1, 1'b0, '0, 1'b0, '0, "R8");
    // R9: load wins over a tick in the same cycle
    drive(1'b1, 1'b1, 1'b1, pk(10, 6, 15, 8, 30, 0), 1'b0, '0, "R9");
    // R10: alarm set, matched by counting, then passed
    drive(1'b0, 1'b1, 1'b0, '0, 1'b1, pk(10, 6, 15, 8, 30, 3), "R10");
    for (int i = 0; i < 5; i++) tick("R10");
    drive(1'b0, 1'b1, 1'b0, '0, 1'b1, pk(10, 6, 15, 8, 30, 5), "R10");
    load(pk(10, 6, 15, 8, 30, 4), "R10");
    tick("R10");
    tick("R10");

    @(negedge clk);
    secTick = 1'b0; wrEn = 1'b0; almWrEn = 1'b0;
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
    finishRun();
  end
endmodule